// File: doc/BRIEF.md
# Bus-Phase Locked Pixel Serializer

This block turns a pattern byte taken from the processor data bus into a serial stream of pixels. It has no character counter of its own. It watches the bus-cycle phase of an opcode fetch and uses that phase to decide when to parallel-load the shift register. It runs on a pixel clock at twice the processor clock rate, so each pixel-clock cycle covers one half of a processor clock period. The processor clock level, the memory-request strobe (active low) and the video-active flag arrive as inputs that are synchronous to the pixel clock.

During an opcode fetch, the refresh part of the cycle drives the memory request low while the processor clock is high in the fourth T-state. The load is armed by that half period. It fires in the low half of the fourth T-state that follows, once the memory request has gone high again. The new pattern therefore appears at the pixel output on the pixel-clock edge that starts T1 of the next fetch. After that edge the register shifts toward its most significant bit on every pixel-clock edge. The pixel output is the top bit of the register, with no retiming stage between them. Zeros fill the register from the bottom, so the output falls back to background after eight pixels. The load strobe output marks the half period in which a load is taken.

Top module: `vpx_pixel_shifter`

## Requirements
- R1: When the load strobe is high, all 8 data-bus bits are captured on that rising pixel-clock edge. Right after that edge the pixel output equals data bit 7.
- R2: A load can only occur in a half period where video is active, the memory request is high (inactive) and the processor clock is low.
- R3: The half period just before the load must have the processor clock high and the memory request low. The same level condition in a T3-low half period that follows a T3-high half period with the memory request high causes no load, so the data on the bus at that time is ignored.
- R4: After a load, one bit leaves per pixel clock (half a processor clock period), most significant bit first. The output after the k-th shift edge is pattern bit 7-k.
- R5: Zeros are shifted in at the low end. From the 8th shift after a load until the next load, the pixel output is 0.
- R6: While video is inactive, the register is cleared on every edge, no load is taken and the strobe stays low. Dropping video in the middle of a pattern forces the output to 0 after the next edge.
- R7: A load takes priority over a shift on the same edge. Reloading while an older pattern is still present gives the new bit 7, not the shifted old value.
- R8: During and right after reset, the pixel output and the load strobe are 0.
- R9: The load strobe is high for exactly one half period per qualifying fetch, and never in two half periods in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, twice the processor clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_clk | input | 1 | Processor clock level, synchronous to clk |
| mreq_n | input | 1 | Memory request strobe, active low |
| video_on | input | 1 | Video-active flag |
| data_bus | input | W (8) | Processor data bus |
| pixel_out | output | 1 | Serial pixel, top bit of the register |
| load_strobe | output | 1 | High during the half period whose ending edge loads |

## Verification
The main corner case is the early low half of T3, where the memory request has not yet fallen. The bench puts a decoy byte on the bus there. A design that used only the level condition would load the decoy and then load again at the end of T4. The bench also holds the memory request low through the low half of T4, and it removes the refresh strobe from the high half of T4; a design that misses either qualification would load anyway. Other scenarios reload over a pattern that is still shifting, which catches a shift winning over a load, and drop video in the middle of a pattern, which catches a register that is not cleared. Running eight idle half periods after a load exposes a design that fills with ones or rotates the pattern instead of returning to background.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

  // One pixel step: move toward the top bit and bring in background.
  function automatic logic [7:0] vpx_shift8(input logic [7:0] word);
    return {word[6:0], 1'b0};
  endfunction

  // Load qualification from the present half period and the one before it.
  function automatic logic vpx_qualify(
    input logic video,
    input logic mreq_n_now,
    input logic cpu_now,
    input logic mreq_n_prev,
    input logic cpu_prev
  );
    logic level_ok;
    logic armed;
    level_ok = video & mreq_n_now & ~cpu_now;
    armed    = ~mreq_n_prev & cpu_prev;
    return level_ok & armed;
  endfunction

endpackage

// File: rtl/vpx_phase_track.sv
module vpx_phase_track
  import vpx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_clk,
  input  logic mreq_n,
  input  logic video_on,
  output logic load_fire
);

  logic prev_mreq_n_q;
  logic prev_cpu_q;

  // History of the half period just finished.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mreq_n_q <= 1'b1;
      prev_cpu_q    <= 1'b0;
    end else begin
      prev_mreq_n_q <= mreq_n;
      prev_cpu_q    <= cpu_clk;
    end
  end

  always_comb begin
    load_fire = vpx_qualify(video_on, mreq_n, cpu_clk, prev_mreq_n_q, prev_cpu_q);
  end

endmodule

// File: rtl/vpx_shreg.sv
module vpx_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         video_on,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q
);

  localparam int MSB = W - 1;

  logic [W-1:0] shifted;

  generate
    if (W == 8) begin : g_pkg_shift
      always_comb shifted = vpx_pkg::vpx_shift8(word_q);
    end else begin : g_gen_shift
      always_comb shifted = {word_q[MSB-1:0], 1'b0};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (!video_on) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= din;
    end else begin
      word_q <= shifted;
    end
  end

endmodule

// File: rtl/vpx_pixel_shifter.sv
module vpx_pixel_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_clk,
  input  logic         mreq_n,
  input  logic         video_on,
  input  logic [W-1:0] data_bus,
  output logic         pixel_out,
  output logic         load_strobe
);

  localparam int MSB = W - 1;

  logic         load_fire;
  logic [W-1:0] word_q;

  vpx_phase_track u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_clk  (cpu_clk),
    .mreq_n   (mreq_n),
    .video_on (video_on),
    .load_fire(load_fire)
  );

  vpx_shreg #(.W(W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .video_on(video_on),
    .load    (load_fire),
    .din     (data_bus),
    .word_q  (word_q)
  );

  assign pixel_out   = word_q[MSB];
  assign load_strobe = load_fire;

endmodule

// File: rtl/vpx_pixel_shifter_chk.sv
module vpx_pixel_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cpu_clk,
  input logic         mreq_n,
  input logic         video_on,
  input logic [W-1:0] data_bus,
  input logic         load_strobe,
  input logic [W-1:0] word_q
);

  a_r1_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> word_q == $past(data_bus));

  a_r2_strobe_level: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> (video_on && mreq_n && !cpu_clk));

  a_r3_refresh_before: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> ($past(cpu_clk) && !$past(mreq_n)));

  a_r4_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && !load_strobe) |=> word_q == {$past(word_q[W-2:0]), 1'b0});

  a_r6_cleared_off: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |=> word_q == '0);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !load_strobe);

endmodule

bind vpx_pixel_shifter vpx_pixel_shifter_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_clk    (cpu_clk),
  .mreq_n     (mreq_n),
  .video_on   (video_on),
  .data_bus   (data_bus),
  .load_strobe(load_strobe),
  .word_q     (word_q)
);

// File: tb/vpx_pixel_shifter_tb.sv
module vpx_pixel_shifter_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_clk = 1'b1;
  logic       mreq_n = 1'b1;
  logic       video_on = 1'b0;
  logic [7:0] data_bus = 8'h00;
  logic       pixel_out;
  logic       load_strobe;

  int checks = 0;
  int errors = 0;
  logic strb_seen;
  logic pix_seen;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpx_pixel_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .mreq_n(mreq_n),
    .video_on(video_on), .data_bus(data_bus),
    .pixel_out(pixel_out), .load_strobe(load_strobe)
  );

  function automatic logic bitof(input logic [7:0] p, input int k);
    if (k < 0 || k > 7) return 1'b0;
    return p[7-k];
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // One half processor period: drive, record strobe, pass an edge, record pixel.
  task automatic half(input logic c, input logic m, input logic v, input logic [7:0] d);
    @(negedge clk);
    cpu_clk = c; mreq_n = m; video_on = v; data_bus = d;
    #1 strb_seen = load_strobe;
    @(posedge clk);
    #1 pix_seen = pixel_out;
  endtask

  // Opcode fetch of 8 half periods. prevp/k0 describe the pattern already shifting.
  task automatic m1(input string req, input logic v, input logic [7:0] d,
                    input logic early, input logic refresh, input logic t4l_mreq,
                    input logic [7:0] prevp, input int k0);
    logic c_s [8];
    logic m_s [8];
    logic exp_load;
    c_s = '{1,0,1,0,1,0,1,0};
    m_s = '{1,0,0,0,1,!early,!refresh,t4l_mreq};
    exp_load = v && refresh && t4l_mreq;
    for (int h = 0; h < 8; h++) begin
      half(c_s[h], m_s[h], v, (h == 5) ? 8'hFF : (h == 7 ? d : 8'h00));
      if (h < 7) begin
        check((h == 5) ? "R3" : "R9", strb_seen, 1'b0, "strobe before T4 low");
        check("R4", pix_seen, v ? bitof(prevp, k0 + 1 + h) : 1'b0, "pixel during fetch");
      end else begin
        check("R2", strb_seen, exp_load, "strobe in T4 low");
        check("R1", pix_seen, exp_load ? d[7] : (v ? bitof(prevp, k0 + 8) : 1'b0),
              "pixel after T1 rise");
      end
    end
  endtask

  // Idle half periods with memory request inactive; checks shifting out.
  task automatic idle_out(input string req, input logic [7:0] p, input int k0, input int n);
    for (int i = 0; i < n; i++) begin
      half((i % 2) == 0, 1'b1, 1'b1, 8'hC3);
      check("R9", strb_seen, 1'b0, "strobe while idle");
      check(req, pix_seen, bitof(p, k0 + 1 + i), "shifted pixel");
    end
  endtask

  task automatic t_reset;
    #1;
    check("R8", pixel_out, 1'b0, "pixel in reset");
    check("R8", load_strobe, 1'b0, "strobe in reset");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    half(1'b1, 1'b1, 1'b1, 8'h00);
    check("R8", pix_seen, 1'b0, "pixel after reset");
    check("R8", strb_seen, 1'b0, "strobe after reset");
  endtask

  task automatic t_early_t3;
    m1("R3", 1'b1, 8'hA5, 1'b1, 1'b1, 1'b1, 8'h00, 8);
    idle_out("R5", 8'hA5, 0, 9);
  endtask

  task automatic t_plain;
    m1("R1", 1'b1, 8'h81, 1'b0, 1'b1, 1'b1, 8'h00, 8);
    idle_out("R4", 8'h81, 0, 8);
  endtask

  task automatic t_reload;
    m1("R1", 1'b1, 8'h0F, 1'b0, 1'b1, 1'b1, 8'h00, 8);
    m1("R7", 1'b1, 8'hF0, 1'b0, 1'b1, 1'b1, 8'h0F, 0);
    idle_out("R7", 8'hF0, 0, 8);
  endtask

  task automatic t_no_refresh;
    m1("R3", 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 8'h00, 8);
    check("R3", pix_seen, 1'b0, "no load without refresh strobe");
    m1("R2", 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00, 8);
    check("R2", pix_seen, 1'b0, "no load while request held low");
  endtask

  task automatic t_video_off;
    m1("R6", 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h00, 8);
    check("R6", strb_seen, 1'b0, "strobe with video off");
    check("R6", pix_seen, 1'b0, "pixel with video off");
    m1("R1", 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 8'h00, 8);
    idle_out("R4", 8'hFF, 0, 2);
    half(1'b1, 1'b1, 1'b0, 8'h00);
    check("R6", pix_seen, 1'b0, "pixel cleared mid pattern");
    half(1'b0, 1'b1, 1'b1, 8'h00);
    check("R6", pix_seen, 1'b0, "pattern not restored");
  endtask

  initial begin
    t_reset();
    t_early_t3();
    t_plain();
    t_reload();
    t_no_refresh();
    t_video_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule